// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block turns a serial HDLC line, sampled one bit per strobe, into a stream of frame octets. After it is enabled it stays silent until it sees an opening flag. It then removes stuffed zeros and packs the bits into octets, least significant bit first. The first two octets form a 16-bit address, which is checked against four reference addresses, each with its own mask. A frame that matches none of them produces no output at all.

The block checks the frame check sequence, which is either CRC-16 or CRC-32, selected by a mode input. It never forwards the check octets. It also enforces a maximum octet count per frame, which is set at run time. Delivered octets appear one per `valid_o` pulse. The final delivered octet carries `last_o` and a four-bit status word that reports CRC error, misalignment, excess length and abort.

The line monitor also reports when the line is idle. A run of seven ones aborts the frame in progress.

Top module: `hdlc_rx`

## Requirements
- R1: While `en_i` is high, no octet is delivered until an opening flag (0x7E) has been received, and line bits that arrive before that flag are ignored.
- R2: Stuffed zeros are removed, so a 0 that follows five consecutive data 1s is discarded. Octets are built least significant bit first, and the frame address is {second octet, first octet}.
- R3: A frame is delivered only if, for some index i in 0..3, `(address ^ addr_i[16i+:16]) & mask_i[16i+:16]` is zero. A mask bit of 1 means "compare" and a mask bit of 0 means "don't care". A frame that matches no index delivers no octet and no `last_o`.
- R4: When `crc32_i` is 0, the check is the reflected CRC-16 with polynomial 0x8408. The register starts at all ones, and the transmitter sends the complemented value LSB first. A wrong check sets status bit 0 (crc_err). The two check octets are never delivered.
- R5: When `crc32_i` is 1, the check is the reflected CRC-32 with polynomial 0xEDB88320, under the same conventions, and its four check octets are not delivered.
- R6: The final delivered octet of a frame carries `last_o` together with `status_o`. `last_o` is never high without `valid_o`, and `status_o` is zero on every other cycle. `valid_o` is low in the cycle that follows `last_o`.
- R7: If the number of bits between the flags is not a multiple of 8, status bit 1 (non_aligned) is set, the partial octet is dropped, and crc_err is forced to 0.
- R8: Octets beyond the first `max_len_i` octets of a frame are neither stored nor delivered. The frame then delivers exactly `max_len_i` minus the check length octets, and status bit 2 (too_long) is set with crc_err forced to 0. `max_len_i` must be at least 8.
- R9: Seven consecutive 1s abort the frame. The frame still delivers n minus the check length octets, where n is the number of complete octets received, and the final octet has status bit 3 (abort) set and bits 1 and 0 clear.
- R10: A frame of fewer than 5 octets (CRC-16 mode) or fewer than 7 octets (CRC-32 mode) delivers nothing. A frame of exactly that many octets delivers its 3 header octets.
- R11: `idle_o` goes high once 15 consecutive 1s have been seen on the line, and it drops on the next 0.
- R12: While `en_i` is low, the receiver returns to flag hunting and delivers nothing from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| crc32_i | input | 1 | Check mode: 1 selects CRC-32, 0 selects CRC-16 |
| bit_en_i | input | 1 | Bit strobe; `bit_i` is sampled when it is high |
| bit_i | input | 1 | Serial line bit |
| addr_i | input | N_ADDR*16 | Reference addresses, entry i at [16i+:16] |
| mask_i | input | N_ADDR*16 | Compare masks, entry i at [16i+:16] |
| max_len_i | input | LEN_W | Maximum octets per frame, check octets included |
| data_o | output | 8 | Delivered octet |
| valid_o | output | 1 | `data_o` is valid |
| last_o | output | 1 | Final octet of the frame |
| status_o | output | 4 | {abort, too_long, non_aligned, crc_err}, valid with `last_o` |
| idle_o | output | 1 | Line idle |

## Verification
The bench builds the block with its default parameters: four address comparators and a 12-bit length counter. It drives `max_len_i` at run time, using 64 for ordinary frames and 10 for the over-length case. At these values, both minimum-length boundaries, the truncation point of a frame that is too long, and the all-ones payloads that force stuffing can be reached with frames of a few dozen octets. The masked comparator entry and the unmatched address are both exercised under CRC-16, and CRC-32 mode is run with and without payload.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned BUF_N = 8;
  localparam logic [7:0] FLAG_PAT = 8'h7E;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

  typedef struct packed {
    logic abort;
    logic too_long;
    logic non_aligned;
    logic crc_err;
  } rx_status_t;
endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
  import hdlc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic dbit_v_o,
  output logic dbit_o,
  output logic flag_o,
  output logic abort_o,
  output logic idle_o
);
  logic [7:0] win_q;
  logic [3:0] fill_q, ones_q;
  logic [2:0] run_q;

  logic [7:0] win_d;
  logic       is_flag, is_abort, out_v, drop;

  assign win_d    = {bit_i, win_q[7:1]};
  assign is_flag  = (win_d == FLAG_PAT);
  assign is_abort = bit_i && (ones_q == 4'd6);
  // oldest window bit leaves as data once the window holds no flag bits
  assign out_v    = bit_en_i && fill_q[3];
  assign drop     = out_v && !win_q[0] && (run_q == 3'd5);
  assign dbit_v_o = out_v && !drop;
  assign dbit_o   = win_q[0];
  assign idle_o   = (ones_q == 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      fill_q  <= '0;
      ones_q  <= '0;
      run_q   <= '0;
      flag_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      flag_o  <= bit_en_i && is_flag;
      abort_o <= bit_en_i && is_abort;
      if (bit_en_i) begin
        win_q <= win_d;
        if (!bit_i)                ones_q <= '0;
        else if (ones_q != 4'd15)  ones_q <= ones_q + 4'd1;
        if (is_flag || is_abort) begin
          fill_q <= '0;
          run_q  <= '0;
        end else begin
          if (!fill_q[3]) fill_q <= fill_q + 4'd1;
          if (out_v) run_q <= win_q[0] ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_v_i,
  input  logic bit_i,
  input  logic wide_i,
  output logic ok_o
);
  logic [31:0] crc_q, poly, seed;

  assign poly = wide_i ? 32'hEDB8_8320 : 32'h0000_8408;
  assign seed = wide_i ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  assign ok_o = wide_i ? (crc_q == 32'hDEBB_20E3) : (crc_q[15:0] == 16'hF0B8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= 32'hFFFF_FFFF;
    else if (clr_i)   crc_q <= seed;
    else if (bit_v_i) crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_i) ? poly : 32'h0);
  end
endmodule

// File: rtl/hdlc_rx_addr.sv
module hdlc_rx_addr #(
  parameter int unsigned N_ADDR = 4
) (
  input  logic [15:0]          addr_i,
  input  logic [N_ADDR*16-1:0] ref_i,
  input  logic [N_ADDR*16-1:0] mask_i,
  output logic                 hit_o
);
  logic [N_ADDR-1:0] hit_v;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_cmp
    assign hit_v[g] = ~|((addr_i ^ ref_i[16*g +: 16]) & mask_i[16*g +: 16]);
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned N_ADDR = 4,
  parameter int unsigned LEN_W  = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 crc32_i,
  input  logic                 bit_en_i,
  input  logic                 bit_i,
  input  logic [N_ADDR*16-1:0] addr_i,
  input  logic [N_ADDR*16-1:0] mask_i,
  input  logic [LEN_W-1:0]     max_len_i,
  output logic [7:0]           data_o,
  output logic                 valid_o,
  output logic                 last_o,
  output logic [3:0]           status_o,
  output logic                 idle_o
);
  localparam int unsigned IDX_W = $clog2(BUF_N);

  logic dbit_v, dbit, flag_q, abort_q, crc_ok, hit;

  rx_state_e        state_q;
  logic [2:0]       bcnt_q;
  logic [7:0]       sh_q, addr_lo_q;
  logic [LEN_W-1:0] nbyte_q;
  logic [7:0]       buf_q [BUF_N];
  logic [IDX_W-1:0] fill_q;
  logic             long_q, match_q, tail_q;
  rx_status_t       stat_q, stat_d;

  logic             in_frame, deliver;
  logic [7:0]       byte_d;
  logic [IDX_W-1:0] depth;

  hdlc_rx_line u_line (
    .clk_i, .rst_ni, .bit_en_i, .bit_i,
    .dbit_v_o(dbit_v), .dbit_o(dbit), .flag_o(flag_q), .abort_o(abort_q), .idle_o
  );

  hdlc_rx_crc u_crc (
    .clk_i, .rst_ni, .clr_i(flag_q), .bit_v_i(in_frame && dbit_v), .bit_i(dbit),
    .wide_i(crc32_i), .ok_o(crc_ok)
  );

  hdlc_rx_addr #(.N_ADDR(N_ADDR)) u_addr (
    .addr_i({byte_d, addr_lo_q}), .ref_i(addr_i), .mask_i(mask_i), .hit_o(hit)
  );

  // octets held back: check octets plus the two emitted at close
  assign depth    = crc32_i ? IDX_W'(6) : IDX_W'(4);
  assign in_frame = (state_q == ST_FRAME);
  assign byte_d   = {dbit, sh_q[7:1]};
  assign deliver  = in_frame && (flag_q || abort_q) && match_q
                    && (nbyte_q >= LEN_W'(depth) + LEN_W'(1));

  always_comb begin
    stat_d = '0;
    stat_d.abort    = abort_q;
    stat_d.too_long = long_q;
    if (!abort_q) begin
      stat_d.non_aligned = (bcnt_q != 3'd0);
      stat_d.crc_err     = !crc_ok && (bcnt_q == 3'd0) && !long_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      bcnt_q    <= '0;
      sh_q      <= '0;
      addr_lo_q <= '0;
      nbyte_q   <= '0;
      fill_q    <= '0;
      long_q    <= 1'b0;
      match_q   <= 1'b0;
      tail_q    <= 1'b0;
      stat_q    <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      last_o    <= 1'b0;
      status_o  <= '0;
      for (int i = 0; i < BUF_N; i++) buf_q[i] <= '0;
    end else begin
      valid_o  <= 1'b0;
      last_o   <= 1'b0;
      status_o <= '0;
      if (!en_i) begin
        state_q <= ST_HUNT;
        tail_q  <= 1'b0;
      end else begin
        if (tail_q) begin
          valid_o  <= 1'b1;
          last_o   <= 1'b1;
          data_o   <= buf_q[1];
          status_o <= stat_q;
          tail_q   <= 1'b0;
        end
        if (deliver) begin
          valid_o <= 1'b1;
          data_o  <= buf_q[0];
          tail_q  <= 1'b1;
          stat_q  <= stat_d;
        end
        if (flag_q) begin
          state_q <= ST_FRAME;
          bcnt_q  <= '0;
          nbyte_q <= '0;
          fill_q  <= '0;
          long_q  <= 1'b0;
          match_q <= 1'b0;
        end else if (abort_q) begin
          state_q <= ST_HUNT;
        end else if (in_frame && dbit_v) begin
          sh_q   <= byte_d;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            if (nbyte_q != '1)    nbyte_q   <= nbyte_q + LEN_W'(1);
            if (nbyte_q == '0)    addr_lo_q <= byte_d;
            if (nbyte_q == LEN_W'(1)) match_q <= hit;
            if (nbyte_q < max_len_i) begin
              if (fill_q == depth) begin
                if (match_q) begin
                  valid_o <= 1'b1;
                  data_o  <= buf_q[0];
                end
                for (int i = 0; i < BUF_N - 1; i++) buf_q[i] <= buf_q[i+1];
                buf_q[depth - IDX_W'(1)] <= byte_d;
              end else begin
                buf_q[fill_q] <= byte_d;
                fill_q        <= fill_q + IDX_W'(1);
              end
            end else begin
              long_q <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       valid_o,
  input logic       last_o,
  input logic [3:0] status_o
);
  p_last_has_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_status_on_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 4'd0) |-> last_o);

  p_gap_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);

  p_abort_no_crc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] |-> (status_o[1:0] == 2'b00));

  p_disable_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
endmodule

bind hdlc_rx hdlc_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .valid_o(valid_o), .last_o(last_o), .status_o(status_o)
);

// File: tb/hdlc_rx_bench.sv
module hdlc_rx_bench;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, bit_en = 1'b0, rx = 1'b1, c32 = 1'b0;
  logic [63:0] areg, amask;
  logic [11:0] max_len;
  logic [7:0]  data;
  logic        valid, last, idle;
  logic [3:0]  status;

  hdlc_rx u_hdlc_rx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .crc32_i(c32), .bit_en_i(bit_en), .bit_i(rx),
    .addr_i(areg), .mask_i(amask), .max_len_i(max_len),
    .data_o(data), .valid_o(valid), .last_o(last), .status_o(status), .idle_o(idle)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] rx_q[$];
  int         got_last = 0, last_idx = 0;
  logic [3:0] got_st = '0;
  logic [7:0] fb [64];
  int         fn, ones_run;

  // vector table: address, payload length, corrupt check, all-ones payload, expected count, status
  localparam logic [15:0] T_ADDR [5] = '{16'h1234, 16'hAB77, 16'h5555, 16'h1234, 16'hFFFF};
  localparam int          T_PLEN [5] = '{3, 0, 4, 2, 5};
  localparam bit          T_BAD  [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam bit          T_ONES [5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int          T_EXPN [5] = '{6, 3, 0, 5, 8};
  localparam logic [3:0]  T_EXPS [5] = '{4'h0, 4'h0, 4'h0, 4'h1, 4'h0};

  always @(negedge clk) begin
    if (valid) begin
      rx_q.push_back(data);
      if (last) begin
        got_last++;
        got_st   = status;
        last_idx = rx_q.size();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit b);
    @(negedge clk);
    rx = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic raw_flag();
    for (int i = 0; i < 8; i++) strobe(bit'((8'h7E >> i) & 8'h1));
    ones_run = 0;
  endtask

  task automatic data_bit(input bit b);
    strobe(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin strobe(1'b0); ones_run = 0; end
    end else ones_run = 0;
  endtask

  function automatic logic [31:0] fcs_of(input int n, input bit w);
    logic [31:0] c = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] p = w ? 32'hEDB8_8320 : 32'h0000_8408;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        bit f = c[0] ^ fb[k][j];
        c = c >> 1;
        if (f) c = c ^ p;
      end
    return w ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic build(input logic [15:0] a, input int plen, input bit ones);
    fb[0] = a[7:0];
    fb[1] = a[15:8];
    fb[2] = 8'h03;
    for (int k = 0; k < plen; k++) fb[3+k] = ones ? 8'hFF : ((8'h11 * 8'(k) + 8'h05) & 8'h7F);
    fn = 3 + plen;
  endtask

  task automatic send(input bit w, input bit bad, input int extra, input bit abort_it, input bit with_fcs);
    int total = fn;
    logic [31:0] f;
    if (with_fcs) begin
      f = fcs_of(fn, w);
      for (int k = 0; k < (w ? 4 : 2); k++) fb[fn+k] = f[8*k +: 8];
      total = fn + (w ? 4 : 2);
      if (bad) fb[total-1] = fb[total-1] ^ 8'h01;
    end
    raw_flag(); raw_flag();
    for (int k = 0; k < total; k++)
      for (int j = 0; j < 8; j++) data_bit(fb[k][j]);
    for (int e = 0; e < extra; e++) data_bit(bit'(e % 2));
    if (abort_it) begin
      strobe(1'b0);
      for (int k = 0; k < 8; k++) strobe(1'b1);
    end
    raw_flag(); raw_flag();
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input int exp_n, input logic [3:0] exp_st);
    chk(rx_q.size() == exp_n, req, rx_q.size(), exp_n);
    for (int i = 0; i < exp_n && i < rx_q.size(); i++)
      chk(rx_q[i] == fb[i], req, rx_q[i], fb[i]);
    if (exp_n > 0) begin
      chk(got_last == 1 && last_idx == exp_n, {req, " last"}, last_idx, exp_n);
      chk(got_st == exp_st, {req, " status"}, got_st, exp_st);
    end else begin
      chk(got_last == 0, {req, " no last"}, got_last, 0);
    end
    rx_q.delete();
    got_last = 0;
    last_idx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    areg    = {16'hFFFF, 16'h0000, 16'hAB00, 16'h1234};
    amask   = {16'hFFFF, 16'hFFFF, 16'hFF00, 16'hFFFF};
    max_len = 12'd64;
    ones_run = 0;
    repeat (5) @(negedge clk);
    chk(valid == 1'b0 && last == 1'b0 && status == 4'h0, "R6 reset", {valid, last, status}, 0);
    rst_n = 1'b1;
    en    = 1'b1;

    // R1: bits before any flag are not frame data
    for (int k = 0; k < 48; k++) strobe(bit'(k % 3 == 0));
    repeat (20) @(negedge clk);
    chk(rx_q.size() == 0, "R1 hunt", rx_q.size(), 0);

    // R2 R3 R4: CRC-16 vector table
    for (int t = 0; t < 5; t++) begin
      build(T_ADDR[t], T_PLEN[t], T_ONES[t]);
      send(1'b0, T_BAD[t], 0, 1'b0, 1'b1);
      expect_frame(t == 2 ? "R3 no match" : (t == 3 ? "R4 crc error" : (t == 1 ? "R3 masked R10 min" : "R2 frame")),
                   T_EXPN[t], T_EXPS[t]);
    end

    // R5: CRC-32 mode, with payload and at the 7-octet boundary
    c32 = 1'b1;
    build(16'h1234, 4, 1'b0);
    send(1'b1, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R5 crc32", 7, 4'h0);
    build(16'hFFFF, 0, 1'b0);
    send(1'b1, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R5 R10 crc32 min", 3, 4'h0);
    build(16'h1234, 1, 1'b0);
    send(1'b1, 1'b1, 0, 1'b0, 1'b1);
    expect_frame("R5 crc32 bad", 4, 4'h1);
    c32 = 1'b0;

    // R10: four octets in CRC-16 mode is too short
    fb[0] = 8'h34; fb[1] = 8'h12; fn = 2;
    send(1'b0, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R10 short", 0, 4'h0);

    // R7: three stray bits before the closing flag
    build(16'h1234, 2, 1'b0);
    send(1'b0, 1'b0, 3, 1'b0, 1'b1);
    expect_frame("R7 non aligned", 5, 4'h2);

    // R8: 17-octet frame against a limit of 10
    max_len = 12'd10;
    build(16'h1234, 12, 1'b0);
    send(1'b0, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R8 too long", 8, 4'h4);
    max_len = 12'd64;

    // R9: abort after eight octets
    build(16'h1234, 5, 1'b0);
    send(1'b0, 1'b0, 0, 1'b1, 1'b0);
    expect_frame("R9 abort", 6, 4'h8);

    // R11: idle detection
    for (int k = 0; k < 16; k++) strobe(1'b1);
    chk(idle == 1'b1, "R11 idle set", idle, 1);
    strobe(1'b0);
    chk(idle == 1'b0, "R11 idle clear", idle, 0);
    repeat (20) @(negedge clk);
    expect_frame("R9 idle run no output", 0, 4'h0);

    // R12: disabled receiver delivers nothing, R1: re-enabled one waits for a flag
    en = 1'b0;
    build(16'h1234, 3, 1'b0);
    send(1'b0, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R12 disabled", 0, 4'h0);
    en = 1'b1;
    build(16'hAB01, 2, 1'b0);
    send(1'b0, 1'b0, 0, 1'b0, 1'b1);
    expect_frame("R1 re-enabled", 5, 4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule